// File: doc/BRIEF.md
# Staged-Update Prescaled PWM Timer

This block is a one-channel pulse-width timer with two 32-bit registers on a simple write/read port. One register holds the enable, the hold bit and the prescaler exponent. The other holds a 10-bit period count and a 10-bit high-time count. The counter advances once every 2^d input clocks. The output is high for the first `phase` ticks of every `period` ticks and low for the rest, so the polarity is always active-high.

Software sets the hold bit before it changes period, high time and prescaler. While the hold bit is set, those writes are only captured. Clearing the hold bit releases all of them at once, and the running waveform picks them up at its next period boundary. A zero period or a zero high time is a forbidden setting and never reaches the counter. As a result the output can never show a 0% duty cycle.

Top module: `staged_pwm_timer`

## Requirements
- R1: Offset 0x00 is the control register. Bit 0 is enable, bit 11 is hold, bit 15 is the low bit of the prescaler exponent d, and bits 19:16 hold d>>1. A read returns the last written value of these bits, and all other bits read as zero.
- R2: Offset 0x04 is the count register, with the period in bits 25:16 and the high time in bits 9:0. A read returns the last written fields, and other bits read as zero. Writes to any other offset change nothing, and reads of other offsets return zero.
- R3: One counter tick lasts 2^d clocks, where d = {bits 19:16, bit 15}. Any d above the parameter MAX_DIV (24 by default) behaves as MAX_DIV.
- R4: While running, the output is high while the tick counter is below the high time. It is low from the high time up to period-1, and the counter then wraps to 0.
- R5: A high time greater than or equal to the period keeps the output high without a break. This includes period 1.
- R6: A period or high time of zero never becomes active. With such a setting pending and the block not yet running, the output stays low even with enable set.
- R7: While hold is set, count-register writes and exponent writes are captured and read back, but the waveform does not use them. Clearing hold releases all captured values together.
- R8: Released settings load only at a period boundary, so the period in progress finishes with the old values.
- R9: Enable is applied at once and is not staged. With valid settings, the counter starts at 0 and the output is high from the second clock edge after the enable write. Clearing enable forces the output low from the second edge after the write and resets the prescaler and counter.
- R10: After reset both registers read zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for one clock |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| pwmOut | output | 1 | PWM output, active-high |

## Verification
The waveform is run with a short period and a mid-range high time at d=0, then with d=1 and d=2. This separates errors in tick length from errors in compare position. An over-range exponent, with the bench lowering MAX_DIV to 4, shows whether the exponent saturates or wraps. High time equal to or above the period, and period 1, expose off-by-one errors in the compare. Zero-valued settings under enable show whether the start gate works. A held update that is released partway through a period shows whether the fields are applied together and only at the boundary.

// File: rtl/staged_pwm_timer_pkg.sv
package staged_pwm_timer_pkg;
  localparam int DIV_W      = 5;
  localparam int CTRL_OFS   = 0;
  localparam int COUNT_OFS  = 4;
  localparam int EN_BIT     = 0;
  localparam int HOLD_BIT   = 11;
  localparam int DIVLO_BIT  = 15;
  localparam int DIVHI_LSB  = 16;
  localparam int PER_LSB    = 16;
  localparam int PH_LSB     = 0;
  localparam logic [31:0] CTRL_MASK = 32'h000F_8801;

  typedef struct packed {
    logic clear;   // enable low: zero prescaler and counter
    logic start;   // begin running: zero counters, load pending
    logic run;     // keep counting
    logic active;  // running state (output may be high)
    logic loadOk;  // pending settings are legal
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import staged_pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output ctrlStrobe_t       strobes,
  output logic [CNT_W-1:0]  pendPeriod,
  output logic [CNT_W-1:0]  pendPhase,
  output logic [DIV_W-1:0]  pendDiv
);
  localparam logic [31:0] COUNT_MASK =
    ({{(32-CNT_W){1'b0}}, {CNT_W{1'b1}}} << PER_LSB) |
    ({{(32-CNT_W){1'b0}}, {CNT_W{1'b1}}} << PH_LSB);

  logic [31:0] ctrlWord, countWord;
  logic        selCtrl, selCount;
  logic        enBit, holdBit, running, pendValid;
  logic [DIV_W-1:0] shadowDiv;

  assign selCtrl  = regAddr == ADDR_W'(CTRL_OFS);
  assign selCount = regAddr == ADDR_W'(COUNT_OFS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      countWord <= '0;
    end else if (regWrEn) begin
      if (selCtrl)  ctrlWord  <= regWdata & CTRL_MASK;
      if (selCount) countWord <= regWdata & COUNT_MASK;
    end
  end

  always_comb begin
    regRdata = '0;
    if (selCtrl)       regRdata = ctrlWord;
    else if (selCount) regRdata = countWord;
  end

  assign enBit     = ctrlWord[EN_BIT];
  assign holdBit   = ctrlWord[HOLD_BIT];
  assign shadowDiv = {ctrlWord[DIVHI_LSB +: DIV_W-1], ctrlWord[DIVLO_BIT]};

  // Staging: pending follows the written values unless hold is set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPeriod <= '0;
      pendPhase  <= '0;
      pendDiv    <= '0;
    end else if (!holdBit) begin
      pendPeriod <= countWord[PER_LSB +: CNT_W];
      pendPhase  <= countWord[PH_LSB +: CNT_W];
      pendDiv    <= shadowDiv;
    end
  end

  assign pendValid = (pendPeriod != '0) && (pendPhase != '0);

  always_ff @(posedge clk) begin
    if (!rstN)                     running <= 1'b0;
    else if (!enBit)               running <= 1'b0;
    else if (!running && pendValid) running <= 1'b1;
  end

  always_comb begin
    strobes.clear  = !enBit;
    strobes.start  = enBit && !running && pendValid;
    strobes.run    = enBit && running;
    strobes.active = running;
    strobes.loadOk = pendValid;
  end

  // R7: held values never reach the pending stage
  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rstN)
    holdBit |=> ($stable(pendPeriod) && $stable(pendPhase) && $stable(pendDiv)));
  // R9: clearing enable stops the channel on the next edge
  a_r9_disable_halts: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !running);
  // R6: an illegal pending setting never starts the channel
  a_r6_no_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !pendValid) |=> !running);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import staged_pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int MAX_DIV = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobes,
  input  logic [CNT_W-1:0] pendPeriod,
  input  logic [CNT_W-1:0] pendPhase,
  input  logic [DIV_W-1:0] pendDiv,
  output logic             pwmOut
);
  localparam int PS_W = (MAX_DIV < 1) ? 1 : MAX_DIV;

  logic [CNT_W-1:0] cnt, actPeriod, actPhase;
  logic [DIV_W-1:0] actDiv, effDiv;
  logic [PS_W:0]    presc, termCount;
  logic             tick, wrap;

  assign effDiv    = (pendDiv > DIV_W'(MAX_DIV)) ? DIV_W'(MAX_DIV) : pendDiv;
  assign termCount = ((PS_W+1)'(1) << actDiv) - (PS_W+1)'(1);
  assign tick      = presc == termCount;
  assign wrap      = tick && (cnt == actPeriod - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      presc     <= '0;
      actPeriod <= '0;
      actPhase  <= '0;
      actDiv    <= '0;
    end else if (strobes.clear) begin
      cnt   <= '0;
      presc <= '0;
    end else if (strobes.start) begin
      cnt       <= '0;
      presc     <= '0;
      actPeriod <= pendPeriod;
      actPhase  <= pendPhase;
      actDiv    <= effDiv;
    end else if (strobes.run) begin
      if (tick) begin
        presc <= '0;
        if (wrap) begin
          cnt <= '0;
          if (strobes.loadOk) begin
            actPeriod <= pendPeriod;
            actPhase  <= pendPhase;
            actDiv    <= effDiv;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        presc <= presc + (PS_W+1)'(1);
      end
    end
  end

  assign pwmOut = strobes.active && (cnt < actPhase);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobes.active |-> (cnt < actPeriod));
  a_r6_active_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.active |-> (actPeriod != '0 && actPhase != '0));
  a_r8_mid_period_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !wrap) |=> ($stable(actPeriod) && $stable(actPhase) && $stable(actDiv)));
  a_r3_presc_bound: assert property (@(posedge clk) disable iff (!rstN)
    presc <= termCount);
endmodule

// File: rtl/staged_pwm_timer.sv
module staged_pwm_timer
  import staged_pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int MAX_DIV = 24,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              pwmOut
);
  ctrlStrobe_t      strobes;
  logic [CNT_W-1:0] pendPeriod, pendPhase;
  logic [DIV_W-1:0] pendDiv;

  pwm_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobes(strobes),
    .pendPeriod(pendPeriod), .pendPhase(pendPhase), .pendDiv(pendDiv));

  pwm_datapath #(.CNT_W(CNT_W), .MAX_DIV(MAX_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pendPeriod(pendPeriod),
    .pendPhase(pendPhase), .pendDiv(pendDiv), .pwmOut(pwmOut));
endmodule

// File: tb/staged_pwm_timer_tb_top.sv
module staged_pwm_timer_tb_top;
  localparam int ClkPeriod = 10;
  localparam int DivMax    = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        pwmOut;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 0;
  string curTag = "R10";

  always #(ClkPeriod/2) clk = ~clk;

  staged_pwm_timer #(.MAX_DIV(DivMax)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pwmOut(pwmOut));

  // Behavioural reference model
  int mEn, mHold, mDiv, sPer, sPh;
  int pPer, pPh, pDiv;
  int aPer, aPh, aDiv;
  int mRun, mCnt, mPre;

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mHold = 0; mDiv = 0; sPer = 0; sPh = 0;
      pPer = 0; pPh = 0; pDiv = 0; aPer = 0; aPh = 0; aDiv = 0;
      mRun = 0; mCnt = 0; mPre = 0;
    end else begin
      if (mEn == 0) begin
        mRun = 0; mCnt = 0; mPre = 0;
      end else if (mRun == 0) begin
        if (pPer != 0 && pPh != 0) begin
          mRun = 1; mCnt = 0; mPre = 0;
          aPer = pPer; aPh = pPh; aDiv = (pDiv > DivMax) ? DivMax : pDiv;
        end
      end else if (mPre == (1 << aDiv) - 1) begin
        mPre = 0;
        if (mCnt == aPer - 1) begin
          mCnt = 0;
          if (pPer != 0 && pPh != 0) begin
            aPer = pPer; aPh = pPh; aDiv = (pDiv > DivMax) ? DivMax : pDiv;
          end
        end else mCnt++;
      end else mPre++;
      if (mHold == 0) begin pPer = sPer; pPh = sPh; pDiv = mDiv; end
      if (regWrEn) begin
        if (regAddr == 3'd0) begin
          mEn = int'(regWdata[0]); mHold = int'(regWdata[11]);
          mDiv = int'({regWdata[19:16], regWdata[15]});
        end else if (regAddr == 3'd4) begin
          sPer = int'(regWdata[25:16]); sPh = int'(regWdata[9:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      checks++;
      if (pwmOut !== ((mRun != 0) && (mCnt < aPh))) begin
        failures++;
        $display("FAIL %s pwmOut got=%0b exp=%0b", curTag, pwmOut, (mRun != 0) && (mCnt < aPh));
      end
    end
  end

  function automatic logic [31:0] ctrlW(int en, int hold, int d);
    return (32'(en) & 32'h1) | ((32'(hold) & 32'h1) << 11) |
           ((32'(d) & 32'h1) << 15) | ((32'(d >> 1) & 32'hF) << 16);
  endfunction

  function automatic logic [31:0] cntW(int per, int ph);
    return ((32'(per) & 32'h3FF) << 16) | (32'(ph) & 32'h3FF);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countHigh(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) h++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int h;
    waitClk(3);
    rstN = 1'b1;
    // R10 reset state
    rd(3'd0, v); check("R10 ctrl after reset", v, 32'h0);
    rd(3'd4, v); check("R10 count after reset", v, 32'h0);
    check("R10 pwmOut after reset", 32'(pwmOut), 32'h0);

    // R4 / R9 basic waveform at d=0
    curTag = "R4";
    wr(3'd4, cntW(5, 2));
    wr(3'd0, ctrlW(1, 0, 0));
    check("R9 output high one edge later", 32'(pwmOut), 32'h0);
    @(negedge clk);
    check("R9 first period starts high", 32'(pwmOut), 32'h1);
    waitClk(30);

    // R7 / R8 staged change to d=1, period 4, phase 1
    curTag = "R7";
    wr(3'd0, ctrlW(1, 1, 0));
    wr(3'd4, cntW(4, 1));
    wr(3'd0, ctrlW(1, 1, 1));
    waitClk(12);
    rd(3'd4, v); check("R7 held count captured", v, cntW(4, 1));
    curTag = "R8";
    wr(3'd0, ctrlW(1, 0, 1));
    waitClk(40);

    // R3 d=2
    curTag = "R3";
    wr(3'd0, ctrlW(1, 0, 2));
    waitClk(60);

    // R6 zero settings
    curTag = "R6";
    wr(3'd0, ctrlW(0, 0, 0));
    wr(3'd4, cntW(0, 3));
    wr(3'd0, ctrlW(1, 0, 0));
    countHigh(20, h); check("R6 zero period stays low", 32'(h), 32'h0);
    wr(3'd4, cntW(4, 0));
    countHigh(20, h); check("R6 zero phase stays low", 32'(h), 32'h0);
    wr(3'd4, cntW(4, 2));
    waitClk(20);

    // R5 phase >= period
    curTag = "R5";
    wr(3'd4, cntW(3, 7));
    waitClk(10);
    countHigh(30, h); check("R5 phase above period all high", 32'(h), 32'd30);
    wr(3'd4, cntW(1, 1));
    waitClk(10);
    countHigh(20, h); check("R5 period one all high", 32'(h), 32'd20);
    wr(3'd4, cntW(6, 5));
    waitClk(20);

    // R9 disable mid-period
    curTag = "R9";
    wr(3'd4, cntW(6, 3));
    waitClk(13);
    wr(3'd0, ctrlW(0, 0, 0));
    @(negedge clk);
    check("R9 low after disable", 32'(pwmOut), 32'h0);
    countHigh(10, h); check("R9 stays low while disabled", 32'(h), 32'h0);
    wr(3'd0, ctrlW(1, 0, 0));
    waitClk(20);

    // R3 exponent above MAX_DIV saturates
    curTag = "R3";
    wr(3'd4, cntW(2, 1));
    wr(3'd0, ctrlW(1, 0, 31));
    waitClk(120);

    // R1 / R2 readback and unused offsets
    curTag = "R2";
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R1 ctrl readback mask", v, 32'h000F_8801);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R2 count readback mask", v, 32'h03FF_03FF);
    wr(3'd2, 32'h1234_5678);
    rd(3'd0, v); check("R2 ctrl untouched by stray write", v, 32'h000F_8801);
    rd(3'd4, v); check("R2 count untouched by stray write", v, 32'h03FF_03FF);
    rd(3'd2, v); check("R2 unused offset reads zero", v, 32'h0);
    rd(3'd6, v); check("R2 other offset reads zero", v, 32'h0);
    waitClk(5);

    doneFlag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule